// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Unit

This block gates up to 32 interrupt source lines for one interrupt class (fast or normal, fixed by a parameter) and drives a single request line. Software never has to read, modify and write the mask. Writing ones to the enable address turns the matching sources on. Writing ones to the clear address turns them off. A zero written to either address leaves its bit untouched.

The status word is the sampled raw sources ANDed with the mask. Software reads it and decides which source to serve. The block does no priority encoding and builds no vector. A software-interrupt configuration register holds one forcing bit for each class. The bit that belongs to this unit's class drives source bit 1 into the raw signal word and into the status word. That forced bit ignores the mask.

The register port is synchronous. Writes take effect at the clock edge on which they are presented. Read data is registered and appears one cycle after the read strobe.

Top module: `irq_mask_unit`

## Requirements
- R1: After reset the enable mask, the software configuration, the request output and the read data are all zero.
- R2: A write to offset 0x108 sets each mask bit whose write-data bit is 1. Bits written as 0 keep their value, so this address can never disable a source.
- R3: A write to offset 0x10C clears each mask bit whose write-data bit is 1. All other mask bits are unchanged.
- R4: A read of 0x108 returns the current mask. A read of 0x10C always returns zero.
- R5: A read of offset 0x100 returns the status word. The status word is the raw sources, sampled one clock earlier, ANDed with the mask.
- R6: `irq_req` is the registered OR of all status bits. It follows a change of the source inputs two clock edges later and a mask write one edge later.
- R7: The software configuration register sits at offset 0x110. Bit 2 is the fast-class force and bit 1 is the normal-class force. Reads return only those two bits, and every other written bit is dropped.
- R8: When this unit's force bit is 1, bit 1 of the raw signal word (read at 0x104) and bit 1 of the status word read 1, whatever the mask holds, and `irq_req` rises.
- R9: The force bit of the other class is stored and read back but changes neither the signal word, the status word nor `irq_req`.
- R10: Writes to the status, signal or unmapped offsets change nothing. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| src_in | input | 32 | Raw interrupt source lines |
| irq_req | output | 1 | Interrupt request for this class |

## Verification
The assertions assume that a read and a write never share a cycle on the port. They also assume the source lines are stable around the clock edge, since the block samples them with a single register. The bench drives every strobe, address and source change on the falling edge and raises at most one strobe at a time. Because of that, each set-or-clear rule can be checked against the write data of the edge before.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int unsigned OFS_STATUS = 12'h100;
  localparam int unsigned OFS_SIGNAL = 12'h104;
  localparam int unsigned OFS_EN_SET = 12'h108;
  localparam int unsigned OFS_EN_CLR = 12'h10C;
  localparam int unsigned OFS_SW_CFG = 12'h110;

  localparam int unsigned SW_FAST_POS = 2;
  localparam int unsigned SW_NORM_POS = 1;
  localparam int unsigned SW_SRC_BIT  = 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_SIGNAL,
    SEL_EN,
    SEL_CLR,
    SEL_SW
  } reg_sel_t;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_we,
  input  logic               clr_we,
  input  logic [NUM_SRC-1:0] bits_in,
  output logic [NUM_SRC-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (set_we) begin
      mask_q <= mask_q | bits_in;
    end else if (clr_we) begin
      mask_q <= mask_q & ~bits_in;
    end
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((mask_q & $past(bits_in)) == $past(bits_in))); // R2
  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((mask_q & $past(mask_q)) == $past(mask_q))); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((mask_q & $past(bits_in)) == '0)); // R3
  AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((mask_q & ~$past(bits_in)) == ($past(mask_q) & ~$past(bits_in)))); // R3
endmodule

// File: rtl/irq_sw_cfg.sv
module irq_sw_cfg #(
  parameter bit IS_FAST = 1'b1,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_rd,
  output logic              inject
);
  import irq_mask_pkg::*;

  logic fast_q, norm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_q <= 1'b0;
      norm_q <= 1'b0;
    end else if (we) begin
      fast_q <= wdata[SW_FAST_POS];
      norm_q <= wdata[SW_NORM_POS];
    end
  end

  always_comb begin
    cfg_rd              = '0;
    cfg_rd[SW_FAST_POS] = fast_q;
    cfg_rd[SW_NORM_POS] = norm_q;
  end

  generate
    if (IS_FAST) begin : g_fast
      assign inject = fast_q;
    end else begin : g_norm
      assign inject = norm_q;
    end
  endgenerate

  AST_CFG_RESERVED: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd & ~((DATA_W'(1) << SW_FAST_POS) | (DATA_W'(1) << SW_NORM_POS))) == '0); // R7
endmodule

// File: rtl/irq_status_gen.sv
module irq_status_gen #(
  parameter int NUM_SRC = 32,
  parameter int SRC_BIT = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] mask,
  input  logic               inject,
  output logic [NUM_SRC-1:0] sig,
  output logic [NUM_SRC-1:0] status,
  output logic               irq_q
);
  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] inj_vec;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_in;
  end

  assign inj_vec = inject ? (NUM_SRC'(1) << SRC_BIT) : '0;
  assign sig     = src_q | inj_vec;
  assign status  = (src_q & mask) | inj_vec;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |status;
  end

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (rst)
    (|status) |=> irq_q); // R6
  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (rst)
    !(|status) |=> !irq_q); // R6
  AST_STATUS_IN_SIG: assert property (@(posedge clk) disable iff (rst)
    (status & ~sig) == '0); // R5
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter bit IS_FAST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic              irq_req
);
  import irq_mask_pkg::*;

  reg_sel_t           sel;
  logic [NUM_SRC-1:0] mask_q, sig, status;
  logic [DATA_W-1:0]  cfg_rd, rd_mux;
  logic               inject;

  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
    else if (addr == ADDR_W'(OFS_SIGNAL)) sel = SEL_SIGNAL;
    else if (addr == ADDR_W'(OFS_EN_SET)) sel = SEL_EN;
    else if (addr == ADDR_W'(OFS_EN_CLR)) sel = SEL_CLR;
    else if (addr == ADDR_W'(OFS_SW_CFG)) sel = SEL_SW;
  end

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .set_we  (wr_en && sel == SEL_EN),
    .clr_we  (wr_en && sel == SEL_CLR),
    .bits_in (wdata[NUM_SRC-1:0]),
    .mask_q  (mask_q)
  );

  irq_sw_cfg #(.IS_FAST(IS_FAST), .DATA_W(DATA_W)) u_sw (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en && sel == SEL_SW),
    .wdata  (wdata),
    .cfg_rd (cfg_rd),
    .inject (inject)
  );

  irq_status_gen #(.NUM_SRC(NUM_SRC), .SRC_BIT(SW_SRC_BIT)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .src_in (src_in),
    .mask   (mask_q),
    .inject (inject),
    .sig    (sig),
    .status (status),
    .irq_q  (irq_req)
  );

  always_comb begin
    case (sel)
      SEL_STATUS: rd_mux = DATA_W'(status);
      SEL_SIGNAL: rd_mux = DATA_W'(sig);
      SEL_EN:     rd_mux = DATA_W'(mask_q);
      SEL_SW:     rd_mux = cfg_rd;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(OFS_EN_CLR)) |=> (rdata == '0)); // R4
  AST_FORCE_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    inject |-> status[SW_SRC_BIT]); // R8
  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en)); // R10
endmodule

// File: tb/irq_mask_unit_bench.sv
module irq_mask_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] src_in = '0;
  logic        irq_req;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  irq_mask_unit u_irq_mask_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_in(src_in), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    check(req, rdata, exp);
  endtask

  task automatic set_src(input logic [31:0] s);
    @(negedge clk); src_in = s;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 rdata", rdata, 0);
    check("R1 irq", {31'b0, irq_req}, 0);
    rd_check("R1 mask", 12'h108, 0);
    rd_check("R1 swcfg", 12'h110, 0);
  endtask

  task automatic t_set;
    wr(12'h108, 32'h0000_00F0);
    rd_check("R2 set", 12'h108, 32'h0000_00F0);
    wr(12'h108, 32'h0000_000F);
    rd_check("R2 set keeps", 12'h108, 32'h0000_00FF);
    wr(12'h108, 32'h0);
    rd_check("R2 zero no effect", 12'h108, 32'h0000_00FF);
  endtask

  task automatic t_clear;
    wr(12'h10C, 32'h0000_0030);
    rd_check("R3 clear", 12'h108, 32'h0000_00CF);
    rd_check("R4 clr reads zero", 12'h10C, 0);
  endtask

  task automatic t_status;
    set_src(32'h0000_00A5);
    check("R6 irq high", {31'b0, irq_req}, 1);
    rd_check("R5 status", 12'h100, 32'h0000_0085);
    rd_check("R5 signal", 12'h104, 32'h0000_00A5);
    set_src(32'h0000_0030);
    check("R6 irq low", {31'b0, irq_req}, 0);
    rd_check("R5 masked status", 12'h100, 0);
  endtask

  task automatic t_sw;
    wr(12'h10C, 32'h0000_0002);
    set_src(32'h0);
    wr(12'h110, 32'h0000_0004);
    @(negedge clk);
    check("R8 irq forced", {31'b0, irq_req}, 1);
    rd_check("R8 status forced", 12'h100, 32'h0000_0002);
    rd_check("R8 signal forced", 12'h104, 32'h0000_0002);
    rd_check("R7 cfg read", 12'h110, 32'h0000_0004);
    wr(12'h110, 32'hFFFF_FFFB);
    rd_check("R7 reserved dropped", 12'h110, 32'h0000_0002);
    rd_check("R9 other class ignored", 12'h100, 0);
    check("R9 irq off", {31'b0, irq_req}, 0);
    wr(12'h110, 32'h0);
  endtask

  task automatic t_ignored;
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h104, 32'hFFFF_FFFF);
    wr(12'h1F0, 32'hFFFF_FFFF);
    rd_check("R10 mask unchanged", 12'h108, 32'h0000_00CD);
    rd_check("R10 swcfg unchanged", 12'h110, 0);
    rd_check("R10 unmapped", 12'h1F0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_set();
    t_clear();
    t_status();
    t_sw();
    t_ignored();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule